// File: doc/BRIEF.md
# CAN Error Confinement and Bus-Off Recovery Unit

This unit keeps the transmit and receive error counters of a CAN controller and turns them into the node's fault-confinement state. The protocol engine sends it increment commands, each carrying its own step size, and decrement-by-one commands. From the counters the unit derives a warning flag, an error-passive flag and the bus-off condition. When the node goes bus-off, the unit forces the controller's initialisation bit on. Bus traffic then stays stopped until software clears that bit.

Once software clears the bit, the unit watches the bus value at every sample point. It counts complete runs of eleven recessive bits. At each completed run it writes the "bit-0 error" last-error code, so that software can follow the progress. After 129 runs both counters return to zero and the node is error-active again. Software writes to the initialisation bit during this wait neither shorten nor restart it. An optional one-cycle interrupt request marks entry into bus-off.

The control is a four-state machine:
- `FC_ACTIVE`: both counters are below 128.
- `FC_PASSIVE`: either counter is at 128 or more.
- `FC_BOFF_HOLD`: bus-off, waiting for software to clear the initialisation bit.
- `FC_BOFF_RECOV`: counting idle runs.

Transitions:
- ACTIVE to PASSIVE when either counter reaches 128. PASSIVE to ACTIVE when both counters fall below 128.
- ACTIVE or PASSIVE to BOFF_HOLD when the transmit counter reaches 256.
- BOFF_HOLD to BOFF_RECOV on a clear of the initialisation bit with no set in the same cycle.
- BOFF_RECOV to ACTIVE when the 129th idle run completes.

Top module: `can_fault_confine`

## Requirements
- R1: After reset both counters read 0, `init_q` is 1, and `bus_off`, `warn`, `err_passive`, `lec_wr` and `boff_irq` are 0.
- R2: An increment command adds its 4-bit amount to its counter. The transmit counter saturates at 256 and the receive counter at 511. A decrement command subtracts 1, with a floor of 0. When increment and decrement arrive together, the increment wins. Counters update one cycle after the command.
- R3: `warn` is 1 when either counter is 96 or more, and 0 when both are below 96.
- R4: `err_passive` is 1 outside bus-off when either counter is 128 or more, and 0 when both are below 128.
- R5: When the transmit counter reaches 256 or more, `bus_off` becomes 1, `init_q` is forced to 1, and the transmit counter holds at 256.
- R6: While `init_q` is 1, or while the node is bus-off, increment and decrement commands leave both counters unchanged.
- R7: `boff_irq` pulses for exactly one cycle, together with the rise of `bus_off`, when `irq_en` and `err_irq_en` are both 1. Otherwise it stays 0.
- R8: During bus-off, before software clears the initialisation bit, recessive samples cause no `lec_wr` and do not advance recovery.
- R9: After the initialisation bit is cleared in bus-off, every 11 consecutive recessive samples (`smp_bit`=1) give a one-cycle `lec_wr` with `lec_code`=5. A dominant sample restarts the current run but keeps the number of completed runs.
- R10: At the completion of the 129th run, both counters become 0 and `bus_off` and `warn` drop in the same cycle. At 128 runs the node is still bus-off.
- R11: Setting or clearing the initialisation bit during recovery neither shortens nor restarts the run count.
- R12: `sw_init_set` sets `init_q` and `sw_init_clr` clears it. A set wins over a simultaneous clear. A bus-off entry wins over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_err_inc | input | 1 | Increment transmit counter |
| tx_err_amt | input | 4 | Transmit increment step |
| tx_ok_dec | input | 1 | Decrement transmit counter by 1 |
| rx_err_inc | input | 1 | Increment receive counter |
| rx_err_amt | input | 4 | Receive increment step |
| rx_ok_dec | input | 1 | Decrement receive counter by 1 |
| sw_init_set | input | 1 | Software sets the initialisation bit |
| sw_init_clr | input | 1 | Software clears the initialisation bit |
| smp_vld | input | 1 | Sample-point strobe |
| smp_bit | input | 1 | Bus value at the sample point, 1 = recessive |
| irq_en | input | 1 | Global interrupt enable |
| err_irq_en | input | 1 | Error interrupt enable |
| init_q | output | 1 | Initialisation bit |
| bus_off | output | 1 | Bus-off flag |
| warn | output | 1 | Error warning flag |
| err_passive | output | 1 | Error-passive flag |
| tx_err_cnt | output | 9 | Transmit error counter |
| rx_err_cnt | output | 9 | Receive error counter |
| lec_wr | output | 1 | Last-error-code write strobe |
| lec_code | output | 3 | Code written, 5 while `lec_wr` is 1 |
| boff_irq | output | 1 | Bus-off interrupt request pulse |

## Verification
A counter that drifts from its true value shows up on `tx_err_cnt` or `rx_err_cnt` one cycle after the command. Its effect on `warn` and `err_passive` shows when a threshold is crossed. A run tracker that loses or gains a bit moves a `lec_wr` pulse by at least one sample, so the strobe count and the cycle in which `bus_off` falls reveal an off-by-one in the 11-bit or 129-run limits. A state machine that leaves bus-off too early or too late shows as counters cleared or still held at the wrong cycle.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE     = 2'd0,
        FC_PASSIVE    = 2'd1,
        FC_BOFF_HOLD  = 2'd2,
        FC_BOFF_RECOV = 2'd3
    } fc_state_e;

    localparam int          LEC_W    = 3;
    localparam logic [2:0]  LEC_NONE = 3'd0;
    localparam logic [2:0]  LEC_BIT0 = 3'd5;

endpackage

// File: rtl/fc_err_counter.sv
module fc_err_counter #(
    parameter int CNT_W = 9,
    parameter int AMT_W = 4,
    parameter int SAT   = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             clr,
    input  logic             inc,
    input  logic [AMT_W-1:0] amt,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);
    localparam int               SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] SATV  = SUM_W'(SAT);

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum   = SUM_W'(cnt_q) + SUM_W'(amt);
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (!hold) begin
            if (inc) begin
                if (sum >= SATV) begin
                    cnt_d = SATV[CNT_W-1:0];
                end else begin
                    cnt_d = sum[CNT_W-1:0];
                end
            end else if (dec && (cnt_q != '0)) begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/fc_idle_tracker.sv
module fc_idle_tracker #(
    parameter int IDLE_BITS = 11,
    parameter int RUNS      = 129
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic en,
    input  logic smp_vld,
    input  logic smp_bit,
    output logic run_done,
    output logic all_done
);
    localparam int BIT_W = $clog2(IDLE_BITS);
    localparam int RUN_W = $clog2(RUNS + 1);

    logic [BIT_W-1:0] bit_q;
    logic [RUN_W-1:0] run_q;

    always_comb begin
        run_done = en && smp_vld && smp_bit && (bit_q == BIT_W'(IDLE_BITS - 1));
        all_done = run_done && (run_q == RUN_W'(RUNS - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            bit_q <= '0;
            run_q <= '0;
        end else if (en && smp_vld) begin
            if (!smp_bit) begin
                bit_q <= '0;
            end else if (run_done) begin
                bit_q <= '0;
                run_q <= run_q + 1'b1;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
    import can_fc_pkg::*;
#(
    parameter int CNT_W      = 9,
    parameter int AMT_W      = 4,
    parameter int WARN_LIM   = 96,
    parameter int PASS_LIM   = 128,
    parameter int BOFF_LIM   = 256,
    parameter int IDLE_BITS  = 11,
    parameter int RECOV_RUNS = 129
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err_inc,
    input  logic [AMT_W-1:0] tx_err_amt,
    input  logic             tx_ok_dec,
    input  logic             rx_err_inc,
    input  logic [AMT_W-1:0] rx_err_amt,
    input  logic             rx_ok_dec,
    input  logic             sw_init_set,
    input  logic             sw_init_clr,
    input  logic             smp_vld,
    input  logic             smp_bit,
    input  logic             irq_en,
    input  logic             err_irq_en,
    output logic             init_q,
    output logic             bus_off,
    output logic             warn,
    output logic             err_passive,
    output logic [CNT_W-1:0] tx_err_cnt,
    output logic [CNT_W-1:0] rx_err_cnt,
    output logic             lec_wr,
    output logic [LEC_W-1:0] lec_code,
    output logic             boff_irq
);
    localparam int               REC_SAT = (1 << CNT_W) - 1;
    localparam logic [CNT_W-1:0] WARN_V  = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] PASS_V  = CNT_W'(PASS_LIM);
    localparam logic [CNT_W-1:0] BOFF_V  = CNT_W'(BOFF_LIM);

    fc_state_e        state_q, state_d;
    logic             init_r, init_d;
    logic             lec_r, irq_r;
    logic             hold_cnt, clr_cnt, boff_entry;
    logic             in_boff, in_hold, in_recov;
    logic             run_done, all_done;
    logic [CNT_W-1:0] tec_q, tec_d, rec_q, rec_d;

    // Counters stop whenever INIT stops traffic or the node is bus-off.
    always_comb begin
        in_hold  = (state_q == FC_BOFF_HOLD);
        in_recov = (state_q == FC_BOFF_RECOV);
        in_boff  = in_hold || in_recov;
        hold_cnt = init_r || in_boff;
        clr_cnt  = all_done;
    end

    fc_err_counter #(.CNT_W(CNT_W), .AMT_W(AMT_W), .SAT(BOFF_LIM)) u_tec (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold_cnt),
        .clr   (clr_cnt),
        .inc   (tx_err_inc),
        .amt   (tx_err_amt),
        .dec   (tx_ok_dec),
        .cnt_q (tec_q),
        .cnt_d (tec_d)
    );

    fc_err_counter #(.CNT_W(CNT_W), .AMT_W(AMT_W), .SAT(REC_SAT)) u_rec (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold_cnt),
        .clr   (clr_cnt),
        .inc   (rx_err_inc),
        .amt   (rx_err_amt),
        .dec   (rx_ok_dec),
        .cnt_q (rec_q),
        .cnt_d (rec_d)
    );

    fc_idle_tracker #(.IDLE_BITS(IDLE_BITS), .RUNS(RECOV_RUNS)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (in_hold),
        .en       (in_recov),
        .smp_vld  (smp_vld),
        .smp_bit  (smp_bit),
        .run_done (run_done),
        .all_done (all_done)
    );

    // Next-state logic, evaluated on the counters' next values.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_ACTIVE, FC_PASSIVE: begin
                if (tec_d >= BOFF_V) begin
                    state_d = FC_BOFF_HOLD;
                end else if ((tec_d >= PASS_V) || (rec_d >= PASS_V)) begin
                    state_d = FC_PASSIVE;
                end else begin
                    state_d = FC_ACTIVE;
                end
            end
            FC_BOFF_HOLD: begin
                if (sw_init_clr && !sw_init_set) begin
                    state_d = FC_BOFF_RECOV;
                end
            end
            FC_BOFF_RECOV: begin
                if (all_done) begin
                    state_d = FC_ACTIVE;
                end
            end
            default: state_d = FC_ACTIVE;
        endcase
        boff_entry = !in_boff && (state_d == FC_BOFF_HOLD);
        if (boff_entry || sw_init_set) begin
            init_d = 1'b1;
        end else if (sw_init_clr) begin
            init_d = 1'b0;
        end else begin
            init_d = init_r;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FC_ACTIVE;
            init_r  <= 1'b1;
            lec_r   <= 1'b0;
            irq_r   <= 1'b0;
        end else begin
            state_q <= state_d;
            init_r  <= init_d;
            lec_r   <= run_done;
            irq_r   <= boff_entry && irq_en && err_irq_en;
        end
    end

    // Output decode.
    always_comb begin
        init_q      = init_r;
        bus_off     = in_boff;
        err_passive = (state_q == FC_PASSIVE);
        warn        = (tec_q >= WARN_V) || (rec_q >= WARN_V);
        tx_err_cnt  = tec_q;
        rx_err_cnt  = rec_q;
        lec_wr      = lec_r;
        lec_code    = lec_r ? LEC_BIT0 : LEC_NONE;
        boff_irq    = irq_r;
    end

endmodule

// File: rtl/fc_guard_chk.sv
module fc_guard_chk #(
    parameter int CNT_W    = 9,
    parameter int PASS_LIM = 128,
    parameter int BOFF_LIM = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_q,
    input logic             bus_off,
    input logic             warn,
    input logic             err_passive,
    input logic [CNT_W-1:0] tx_err_cnt,
    input logic [CNT_W-1:0] rx_err_cnt,
    input logic             lec_wr,
    input logic [2:0]       lec_code
);
    // R2
    tec_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err_cnt <= CNT_W'(BOFF_LIM));

    // R4
    passive_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_passive |-> ((tx_err_cnt >= CNT_W'(PASS_LIM)) || (rx_err_cnt >= CNT_W'(PASS_LIM))));

    // R5
    boff_forces_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_off) |-> init_q);

    // R3
    boff_warns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off |-> warn);

    // R6
    init_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_q && !bus_off) |=> ($stable(tx_err_cnt) && $stable(rx_err_cnt)));

    // R9
    lec_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lec_wr |-> (lec_code == 3'd5));

    // R8
    lec_only_boff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lec_wr |-> $past(bus_off));

endmodule

bind can_fault_confine fc_guard_chk #(
    .CNT_W    (CNT_W),
    .PASS_LIM (PASS_LIM),
    .BOFF_LIM (BOFF_LIM)
) u_guard_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_q      (init_q),
    .bus_off     (bus_off),
    .warn        (warn),
    .err_passive (err_passive),
    .tx_err_cnt  (tx_err_cnt),
    .rx_err_cnt  (rx_err_cnt),
    .lec_wr      (lec_wr),
    .lec_code    (lec_code)
);

// File: tb/tb_can_fault_confine.sv
module tb_can_fault_confine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_err_inc = 0, tx_ok_dec = 0, rx_err_inc = 0, rx_ok_dec = 0;
    logic [3:0] tx_err_amt = 0, rx_err_amt = 0;
    logic       sw_init_set = 0, sw_init_clr = 0, smp_vld = 0, smp_bit = 0;
    logic       irq_en = 0, err_irq_en = 0;
    logic       init_q, bus_off, warn, err_passive, lec_wr, boff_irq;
    logic [8:0] tx_err_cnt, rx_err_cnt;
    logic [2:0] lec_code;

    int checks = 0, errors = 0;
    int m_tec, m_rec, m_state, m_bits, m_runs;
    bit m_init, m_stb, m_irq;
    int stb_seen;

    always #2 clk = ~clk;

    can_fault_confine dut (
        .clk(clk), .rst_n(rst_n),
        .tx_err_inc(tx_err_inc), .tx_err_amt(tx_err_amt), .tx_ok_dec(tx_ok_dec),
        .rx_err_inc(rx_err_inc), .rx_err_amt(rx_err_amt), .rx_ok_dec(rx_ok_dec),
        .sw_init_set(sw_init_set), .sw_init_clr(sw_init_clr),
        .smp_vld(smp_vld), .smp_bit(smp_bit),
        .irq_en(irq_en), .err_irq_en(err_irq_en),
        .init_q(init_q), .bus_off(bus_off), .warn(warn), .err_passive(err_passive),
        .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
        .lec_wr(lec_wr), .lec_code(lec_code), .boff_irq(boff_irq)
    );

    function automatic int exp_warn(int t, int r);
        return ((t >= 96) || (r >= 96)) ? 1 : 0;
    endfunction

    function automatic int exp_passive(int st, int t, int r);
        return ((st == 0) && ((t >= 128) || (r >= 128))) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_tec = 0; m_rec = 0; m_state = 0; m_bits = 0; m_runs = 0;
        m_init = 1; m_stb = 0; m_irq = 0;
    endtask

    // Behaviour taken from the requirements; state 0 run, 1 held, 2 recovering.
    task automatic model_step();
        int  t = m_tec;
        int  r = m_rec;
        bit  entry = 0;
        m_stb = 0;
        if (m_state == 0 && !m_init) begin
            if (tx_err_inc) t = (t + int'(tx_err_amt) > 256) ? 256 : t + int'(tx_err_amt);
            else if (tx_ok_dec && t > 0) t = t - 1;
            if (rx_err_inc) r = (r + int'(rx_err_amt) > 511) ? 511 : r + int'(rx_err_amt);
            else if (rx_ok_dec && r > 0) r = r - 1;
        end
        case (m_state)
            0: if (t >= 256) begin m_state = 1; entry = 1; end
            1: if (sw_init_clr && !sw_init_set) begin m_state = 2; m_bits = 0; m_runs = 0; end
            default: if (smp_vld) begin
                if (smp_bit) begin
                    if (m_bits == 10) begin
                        m_bits = 0; m_runs++; m_stb = 1;
                        if (m_runs == 129) begin m_state = 0; t = 0; r = 0; end
                    end else m_bits++;
                end else m_bits = 0;
            end
        endcase
        if (entry || sw_init_set) m_init = 1;
        else if (sw_init_clr) m_init = 0;
        m_irq = entry && irq_en && err_irq_en;
        m_tec = t; m_rec = r;
    endtask

    task automatic compare();
        chk("R2 tx count", int'(tx_err_cnt), m_tec);
        chk("R2 rx count", int'(rx_err_cnt), m_rec);
        chk("R3 warn", int'(warn), exp_warn(m_tec, m_rec));
        chk("R4 passive", int'(err_passive), exp_passive(m_state, m_tec, m_rec));
        chk("R5 bus_off", int'(bus_off), (m_state != 0) ? 1 : 0);
        chk("R12 init", int'(init_q), int'(m_init));
        chk("R9 lec_wr", int'(lec_wr), int'(m_stb));
        if (lec_wr) chk("R9 lec_code", int'(lec_code), 5);
        chk("R7 irq", int'(boff_irq), int'(m_irq));
        if (lec_wr) stb_seen++;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        tx_err_inc = 0; tx_ok_dec = 0; rx_err_inc = 0; rx_ok_dec = 0;
        sw_init_set = 0; sw_init_clr = 0; smp_vld = 0; smp_bit = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        @(posedge clk);
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1;
        compare();
    endtask

    task automatic tx_inc(input int amt);
        tx_err_inc = 1; tx_err_amt = 4'(amt); tick();
    endtask

    task automatic sample(input bit b);
        smp_vld = 1; smp_bit = b; tick();
    endtask

    task automatic enter_busoff();
        sw_init_clr = 1; tick();
        for (int i = 0; i < 32; i++) tx_inc(8);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed = 32'h5eed_c0de;
        void'($urandom(seed));
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 init after reset", int'(init_q), 1);
        chk("R1 counters after reset", int'(tx_err_cnt) + int'(rx_err_cnt), 0);
        chk("R1 flags after reset", int'(bus_off | warn | err_passive | lec_wr | boff_irq), 0);

        // R6 commands ignored while INIT is set
        tx_inc(15);
        rx_err_inc = 1; rx_err_amt = 4'd9; tick();
        chk("R6 frozen under init", int'(tx_err_cnt) + int'(rx_err_cnt), 0);

        // R12 set wins over clear
        sw_init_set = 1; sw_init_clr = 1; tick();
        chk("R12 set wins", int'(init_q), 1);
        sw_init_clr = 1; tick();

        // R2/R3 warning threshold at 96
        for (int i = 0; i < 11; i++) tx_inc(8);
        chk("R3 below 96", int'(warn), 0);
        tx_inc(8);
        chk("R3 at 96", int'(warn), 1);
        tx_ok_dec = 1; tick();
        chk("R3 back to 95", int'(warn), 0);
        tx_err_inc = 1; tx_err_amt = 4'd3; tx_ok_dec = 1; tick();
        chk("R2 inc wins over dec", int'(tx_err_cnt), 98);

        // R4 receive counter drives passive at 128
        for (int i = 0; i < 8; i++) begin rx_err_inc = 1; rx_err_amt = 4'd15; tick(); end
        rx_err_inc = 1; rx_err_amt = 4'd7; tick();
        chk("R4 passive at 127", int'(err_passive), 0);
        rx_err_inc = 1; rx_err_amt = 4'd1; tick();
        chk("R4 passive at 128", int'(err_passive), 1);
        rx_ok_dec = 1; tick();
        chk("R4 active again at 127", int'(err_passive), 0);

        // random mixed traffic, including bus-off and recovery
        for (int n = 0; n < 30000; n++) begin
            int r = int'($urandom_range(0, 99));
            irq_en = ($urandom_range(0, 3) != 0); err_irq_en = ($urandom_range(0, 3) != 0);
            if (r < 30) begin tx_err_inc = 1; tx_err_amt = 4'($urandom_range(0, 15)); end
            if (r >= 20 && r < 55) tx_ok_dec = 1;
            if (r >= 40 && r < 70) begin rx_err_inc = 1; rx_err_amt = 4'($urandom_range(0, 15)); end
            if (r >= 60) rx_ok_dec = 1;
            if ($urandom_range(0, 199) == 0) sw_init_set = 1;
            if ($urandom_range(0, 19) == 0) sw_init_clr = 1;
            smp_vld = ($urandom_range(0, 4) != 0);
            smp_bit = ($urandom_range(0, 19) != 0);
            tick();
        end

        // directed bus-off with interrupts enabled
        irq_en = 1; err_irq_en = 1;
        do_reset();
        sw_init_clr = 1; tick();
        for (int i = 0; i < 31; i++) tx_inc(8);
        chk("R5 not busoff at 248", int'(bus_off), 0);
        tx_inc(8);
        chk("R5 busoff at 256", int'(bus_off), 1);
        chk("R5 init forced", int'(init_q), 1);
        chk("R7 irq pulse", int'(boff_irq), 1);
        tick();
        chk("R7 irq single cycle", int'(boff_irq), 0);
        tx_inc(15);
        chk("R6 frozen in busoff", int'(tx_err_cnt), 256);

        // R8 recessive samples before INIT clear do nothing
        stb_seen = 0;
        for (int i = 0; i < 22; i++) sample(1);
        chk("R8 no strobe while held", stb_seen, 0);

        sw_init_clr = 1; tick();
        for (int i = 0; i < 5; i++) sample(1);
        sample(0);
        for (int i = 0; i < 10; i++) sample(1);
        chk("R9 dominant restarts run", stb_seen, 0);
        sample(1);
        chk("R9 first run flagged", stb_seen, 1);
        for (int k = 1; k < 128; k++) begin
            if (k == 50) sw_init_set = 1;
            if (k == 60) sw_init_clr = 1;
            if (k == 70) begin sw_init_set = 1; sw_init_clr = 1; end
            for (int i = 0; i < 11; i++) sample(1);
        end
        chk("R11 run count kept across INIT writes", stb_seen, 128);
        chk("R10 still busoff at 128 runs", int'(bus_off), 1);
        for (int i = 0; i < 11; i++) sample(1);
        chk("R10 busoff clears", int'(bus_off), 0);
        chk("R10 counters zero", int'(tx_err_cnt) + int'(rx_err_cnt), 0);
        chk("R10 warn clears", int'(warn), 0);
        chk("R9 total strobes", stb_seen, 129);

        // R7 no interrupt without the error enable
        err_irq_en = 0;
        sw_init_clr = 1; tick();
        enter_busoff();
        chk("R7 busoff without irq", int'(bus_off), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule